// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a small internal register bank. It takes oversampled SCL and SDA inputs, recognises START, repeated START and STOP, and answers to a 7-bit device address. Six of the address bits are fixed. The lowest bit comes from a strap input, so two copies of the block can share one bus.

After its address is acknowledged, the block takes a pointer byte. The low seven bits of that byte select a register, and the top bit chooses whether the pointer steps forward after each data byte. Write data then flows into the bank through a single-cycle write strobe. To read, the master sets the pointer, issues a repeated START with the read address, and receives bytes MSB first. Each read byte is fetched through a single-cycle read strobe at the moment the byte is needed.

The register bank itself sits outside the block. Its read data must be valid combinationally in the same cycle as the read strobe. The system clock must run at least sixteen times faster than SCL.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, `sda_oe` is 0 and neither `reg_wr_en` nor `reg_rd_en` is asserted while the bus is idle.
- R2: A STOP (SDA rising while SCL is high) releases SDA. Bits clocked after a STOP are ignored and get no acknowledge until a new START (SDA falling while SCL is high).
- R3: The block acknowledges an address byte only if it equals {6'b101110, strap, rw}. That gives B8h/B9h with the strap at 0 and BAh/BBh with the strap at 1. Any other address gets no acknowledge, and the following bytes of that transfer get no acknowledge and cause no register access.
- R4: For every byte the block receives while addressed (address, pointer, write data), it pulls SDA low from the falling edge after the eighth SCL pulse through the whole ninth SCL pulse.
- R5: The first byte after a write address is the pointer byte. Bits [6:0] set the register index and bit 7 enables auto-increment. This byte causes no register write.
- R6: Each write data byte produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the current pointer and `reg_wdata` equal to the byte.
- R7: With auto-increment on, the pointer advances by one after every data byte, in both writes and reads, and wraps from 127 to 0.
- R8: With auto-increment off, every data byte of the transfer uses the same register.
- R9: After a read address, the block shifts out the register at the pointer MSB first, driving each bit during SCL low. It fetches the next register each time the master acknowledges.
- R10: A NACK from the master after a read byte ends transmission. SDA stays released and no read strobe is issued until the next START.
- R11: `sda_oe` changes only while SCL is low. The only exception is a forced release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| strap_lsb | input | 1 | Sets bit 0 of the device address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 7 | Register index for the bank port |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the same cycle as `reg_rd_en` |

## Verification
The following are checked on every cycle: the release of SDA after a STOP, silence while a transfer is ignored, SDA held low across an acknowledge pulse, single-cycle write strobes, the pointer stepping or holding after each write, and `sda_oe` changing only during SCL low. The bench scenarios alone show the rest. These are the address decode against both strap settings, where bytes actually land in the bank, the byte order and content of reads across a repeated START, pointer wrap at 127, and the silence that follows a master NACK or a stray byte after a STOP.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [5:0] DEV_ID_HI = 6'b101110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_SUB, ST_WDATA, ST_TX, ST_MACK, ST_IGNORE
    } phase_e;

    typedef enum logic [1:0] { NX_SUB, NX_WDATA, NX_TX } after_ack_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic strap);
        return b[BYTE_W-1:1] == {DEV_ID_HI, strap};
    endfunction
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync
    import i2c_rs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output line_t ln
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign ln.level = chain[STAGES-1];
    assign ln.rise  = chain[STAGES-1] & ~prev;
    assign ln.fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond
    import i2c_rs_pkg::*;
(
    input  line_t scl,
    input  line_t sda,
    output logic  start_det,
    output logic  stop_det
);
    logic scl_held;
    assign scl_held  = scl.level & ~scl.rise;
    assign start_det = scl_held & sda.fall;
    assign stop_det  = scl_held & sda.rise;
endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
    import i2c_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_t             scl,
    input  line_t             sda,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap,
    output logic              sda_oe,
    output logic [IDX_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    phase_e            st;
    after_ack_e        nx;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  ptr;
    logic              inc_en;
    logic              oe;
    logic              nack;
    logic              quiet, rx_bit, rx_done, fetch;

    assign quiet   = ~start_det & ~stop_det;
    assign rx_bit  = scl.rise & (cnt != FULL);
    assign rx_done = quiet & scl.fall & (cnt == FULL);
    assign fetch   = quiet & scl.fall &
                     ((st == ST_ACK && nx == NX_TX) || (st == ST_MACK && !nack));

    assign reg_rd_en = fetch;
    assign reg_wr_en = rx_done & (st == ST_WDATA);
    assign reg_wdata = sh;
    assign reg_addr  = ptr;
    assign sda_oe    = oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            nx     <= NX_SUB;
            sh     <= '0;
            cnt    <= '0;
            ptr    <= '0;
            inc_en <= 1'b0;
            oe     <= 1'b0;
            nack   <= 1'b0;
        end else if (start_det) begin
            st  <= ST_ADDR;
            cnt <= '0;
            oe  <= 1'b0;
        end else if (stop_det) begin
            st <= ST_IDLE;
            oe <= 1'b0;
        end else if (fetch) begin
            sh  <= reg_rdata;
            oe  <= ~reg_rdata[BYTE_W-1];
            cnt <= CNT_W'(1);
            st  <= ST_TX;
            if (inc_en) ptr <= ptr + IDX_W'(1);
        end else begin
            case (st)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (rx_bit) begin
                        sh  <= {sh[BYTE_W-2:0], sda.level};
                        cnt <= cnt + CNT_W'(1);
                    end else if (rx_done) begin
                        cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (dev_match(sh, strap)) begin
                                oe <= 1'b1;
                                st <= ST_ACK;
                                nx <= sh[0] ? NX_TX : NX_SUB;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else begin
                            if (st == ST_SUB) begin
                                ptr    <= sh[IDX_W-1:0];
                                inc_en <= sh[BYTE_W-1];
                            end else if (inc_en) begin
                                ptr <= ptr + IDX_W'(1);
                            end
                            oe <= 1'b1;
                            st <= ST_ACK;
                            nx <= NX_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl.fall) begin
                        oe  <= 1'b0;
                        cnt <= '0;
                        st  <= (nx == NX_SUB) ? ST_SUB : ST_WDATA;
                    end
                end
                ST_TX: begin
                    if (scl.fall) begin
                        if (cnt == FULL) begin
                            oe <= 1'b0;
                            st <= ST_MACK;
                        end else begin
                            oe  <= ~sh[BYTE_W-2];
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (scl.rise) nack <= sda.level;
                    else if (scl.fall && nack) st <= ST_IGNORE;
                end
                default: ;
            endcase
        end
    end

    a_r2_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);
    a_r3_ignore_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> (!sda_oe && !reg_wr_en && !reg_rd_en));
    a_r4_ack_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && scl.level && !scl.rise) |-> sda_oe);
    a_r6_one_write: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && inc_en) |=> (ptr == $past(ptr) + IDX_W'(1)));
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !inc_en) |=> (ptr == $past(ptr)));
    a_r11_oe_low_phase: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !$past(scl.level));
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              strap_lsb,
    output logic              sda_oe,
    output logic [IDX_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    line_t             ln [NLINES];
    logic              start_det, stop_det;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (raw[g]),
            .ln  (ln[g])
        );
    end

    i2c_rs_cond u_cond (
        .scl       (ln[0]),
        .sda       (ln[1]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rs_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl       (ln[0]),
        .sda       (ln[1]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_lsb),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       strap = 1'b0;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;
    logic [7:0] bank [128];
    int         wr_cnt = 0, rd_cnt = 0, r11_viol = 0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;
    logic       prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = msda & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_regslave u_i2c_regslave (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .strap_lsb(strap),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'h00;
        end else begin
            if (reg_wr_en) begin
                bank[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd_en) rd_cnt <= rd_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && scl) r11_viol <= r11_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_n(5); msda = 1'b1; wait_n(5); scl = 1'b1;
        wait_n(5); msda = 1'b0; wait_n(5); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(5); msda = 1'b0; wait_n(5); scl = 1'b1;
        wait_n(5); msda = 1'b1; wait_n(5);
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        wait_n(5); msda = b; wait_n(5); scl = 1'b1;
        wait_n(5); seen = sda_line; wait_n(5); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            b[i] = s;
        end
        bit_xfer(~mack, s);
    endtask

    // strap, device address, pointer byte, data, address acknowledged
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 7'h5C, 8'h05, 8'hA5, 1'b1},
        {1'b1, 7'h5D, 8'h10, 8'h3C, 1'b1},
        {1'b0, 7'h5D, 8'h11, 8'h77, 1'b0},
        {1'b1, 7'h5C, 8'h12, 8'h88, 1'b0},
        {1'b1, 7'h5D, 8'h7F, 8'h01, 1'b1},
        {1'b0, 7'h12, 8'h13, 8'h99, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] rb;
        int         wc, rc, zeros;
        wait_n(4);
        rst = 1'b0;
        wait_n(10);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 no strobes after reset", reg_wr_en | reg_rd_en, 0);

        for (int v = 0; v < 6; v++) begin
            strap = VEC[v][24];
            wait_n(4);
            wc = wr_cnt;
            bus_start();
            send_byte({VEC[v][23:17], 1'b0}, ack);
            chk("R3 address acknowledge", ack, VEC[v][0]);
            if (VEC[v][0]) chk("R4 ack on address", ack, 1);
            send_byte(VEC[v][16:9], ack);
            chk("R4 ack on pointer", ack, VEC[v][0]);
            chk("R5 pointer byte writes nothing", wr_cnt - wc, 0);
            send_byte(VEC[v][8:1], ack);
            chk("R4 ack on data", ack, VEC[v][0]);
            bus_stop();
            wait_n(4);
            if (VEC[v][0]) begin
                chk("R6 data landed", bank[VEC[v][15:9]], VEC[v][8:1]);
                chk("R6 one write strobe", wr_cnt - wc, 1);
            end else begin
                chk("R3 no write when unaddressed", wr_cnt - wc, 0);
                chk("R3 bank untouched", bank[VEC[v][15:9]], 0);
            end
        end

        // R5/R7: auto-increment write at index 20h
        strap = 1'b0;
        wait_n(4);
        bus_start();
        send_byte(8'hB8, ack); send_byte(8'hA0, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
        bus_stop(); wait_n(4);
        chk("R5 index from low bits", bank[7'h20], 8'h11);
        chk("R7 increment 1", bank[7'h21], 8'h22);
        chk("R7 increment 2", bank[7'h22], 8'h33);

        // R7: wrap from 127 to 0
        bus_start();
        send_byte(8'hB8, ack); send_byte(8'hFF, ack);
        send_byte(8'h44, ack); send_byte(8'h55, ack);
        bus_stop(); wait_n(4);
        chk("R7 last index", bank[7'h7F], 8'h44);
        chk("R7 wrap to zero", bank[7'h00], 8'h55);

        // R8: no increment, same register
        wc = wr_cnt;
        bus_start();
        send_byte(8'hB8, ack); send_byte(8'h30, ack);
        send_byte(8'h61, ack); send_byte(8'h62, ack); send_byte(8'h63, ack);
        bus_stop(); wait_n(4);
        chk("R8 final value held register", bank[7'h30], 8'h63);
        chk("R8 neighbour untouched", bank[7'h31], 8'h00);
        chk("R8 three strobes", wr_cnt - wc, 3);

        // R9: read with repeated START, auto-increment
        bus_start();
        send_byte(8'hB8, ack); send_byte(8'hA0, ack);
        bus_start();
        send_byte(8'hB9, ack);
        chk("R3 read address B9h acked", ack, 1);
        recv_byte(1'b1, rb); chk("R9 read byte 0", rb, 8'h11);
        recv_byte(1'b1, rb); chk("R9 read byte 1", rb, 8'h22);
        recv_byte(1'b0, rb); chk("R9 read byte 2", rb, 8'h33);
        // R10: after NACK the slave is silent
        rc = rd_cnt;
        zeros = 0;
        for (int i = 0; i < 9; i++) begin
            logic s;
            bit_xfer(1'b1, s);
            if (!s) zeros++;
        end
        chk("R10 sda released after nack", zeros, 0);
        chk("R10 no read strobe after nack", rd_cnt - rc, 0);
        bus_stop();

        // R8/R9: read without increment
        bus_start();
        send_byte(8'hB8, ack); send_byte(8'h20, ack);
        bus_start();
        send_byte(8'hB9, ack);
        recv_byte(1'b1, rb); chk("R8 read same register first", rb, 8'h11);
        recv_byte(1'b0, rb); chk("R8 read same register again", rb, 8'h11);
        bus_stop();

        // R3/R9: strap high, BAh/BBh, read across index 0
        strap = 1'b1;
        wait_n(4);
        bus_start();
        send_byte(8'hBA, ack); send_byte(8'h80, ack);
        bus_start();
        send_byte(8'hBB, ack);
        chk("R3 read address BBh acked", ack, 1);
        recv_byte(1'b1, rb); chk("R9 strap high byte 0", rb, 8'h55);
        recv_byte(1'b0, rb); chk("R9 strap high byte 1", rb, 8'h00);
        bus_stop();

        // R2: byte after STOP with no START is ignored
        wc = wr_cnt;
        send_byte(8'hBA, ack);
        chk("R2 no ack after stop", ack, 0);
        send_byte(8'h55, ack);
        chk("R2 no write after stop", wr_cnt - wc, 0);
        bus_stop();

        wait_n(4);
        chk("R11 sda_oe changed only during SCL low", r11_viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule